// File: doc/BRIEF.md
# Serial ADC Mux-Addressing Controller

This block drives a family of 8-bit serial successive-approximation converters. The family members differ only in how many multiplexer address bits they accept: zero, one, two or three. A static configuration input gives that count. A request carries a channel number and a flag that picks single-ended or differential input. The controller turns these into a command word and runs one full-duplex serial frame of sixteen clocks, with chip select held low throughout. It then hands back the 8-bit conversion result together with a one-cycle done strobe.

With one or more address bits, the command holds a start bit, a mode bit, an odd/sign bit and the pair-select bits. The command is placed so that the result's MSB lands on the first bit of the second received byte. With no address bits, the data output stays undriven. The result is taken from the frame after skipping the high-impedance slot and the leading zero bit.

The serial clock idles low. Data out changes while the clock is low, and data in is sampled on each rising edge. The clock half-period is a parameter counted in system clocks.

Top module: `sar_mux_ctl`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, done is 0 and result is 0.
- R2: Each conversion gives exactly 16 rising sclk edges, and cs_n stays 0 from the first of them to the last.
- R3: For a mux-bit count M of 1 to 3, the first 8 bits on mosi (sent MSB first) form byte B shifted left by one. In B, bit M+1 is 1, bit M is 1 for single-ended (req_diff=0) and 0 for differential, and bit M-1 is the channel LSB. Bits M-2..0 hold the channel divided by two. The last 8 bits sent are 0.
- R4: For M of 1 to 3, result equals the last 8 bits received, with the first bit received taken as bit 15 of the frame (frame bits 7:0).
- R5: For M of 0, mosi_oe stays 0 for the whole frame, and result equals bits 13:6 of the 16 received bits.
- R6: mosi changes only while sclk is low, so it is stable at every rising edge.
- R7: busy rises in the cycle after an accepted req_start and falls in the cycle done pulses. done is high for one cycle only.
- R8: A req_start that arrives while busy is 1 starts no frame and leaves the frame in progress unchanged.
- R9: cs_n stays high for at least one full sclk period (2*HALF_DIV system clocks) between two frames, even when req_start is held high.
- R10: sclk is 0 whenever cs_n is 1.
- R11: Channel bits at index M and above are ignored. For M=1, channel 7 sends the same command as channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mux_bits | input | 2 | Number of mux address bits of the attached converter (0 to 3); static |
| req_start | input | 1 | Conversion request, taken when idle |
| req_chan | input | 3 | Channel number (pair select and odd/sign) |
| req_diff | input | 1 | 1 for differential, 0 for single-ended |
| busy | output | 1 | High from an accepted request until done |
| done | output | 1 | One-cycle strobe when result is valid |
| result | output | 8 | Last conversion result |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Command data to the converter |
| mosi_oe | output | 1 | Output enable for mosi, low when no command is sent |
| miso | input | 1 | Conversion data from the converter |

## Verification
The assertions assume that cfg_mux_bits does not change while a frame runs, and that miso only needs to be settled at rising sclk edges. The bench changes the configuration only while busy is low. It drives miso from a converter model that updates its output on system-clock falling edges, after an sclk falling edge or the fall of chip select. Requests are applied on falling clock edges, so each one meets exactly one sampling edge unless it is deliberately held high.

// File: rtl/sarmux_pkg.sv
package sarmux_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } sarmux_state_e;
endpackage

// File: rtl/sarmux_cmd.sv
module sarmux_cmd #(
   parameter int DATA_W  = 8,
   parameter int FRAME   = 16,
   parameter int CH_W    = 3,
   parameter int MAX_MUX = 3,
   localparam int MUX_W  = $clog2(MAX_MUX + 1)
) (
   input  logic [MUX_W-1:0] mux_bits,
   input  logic [CH_W-1:0]  chan,
   input  logic             diff,
   output logic [FRAME-1:0] word,
   output logic             drive
);
   localparam int PAD = FRAME - DATA_W;

   generate
      if (MAX_MUX + 3 > DATA_W) begin : g_bad_mux
         $error("sarmux_cmd: command does not fit one byte");
      end
      if (CH_W < MAX_MUX) begin : g_bad_ch
         $error("sarmux_cmd: channel field narrower than mux bits");
      end
   endgenerate

   logic [DATA_W-1:0] body;

   always_comb begin
      int m;
      m    = int'(mux_bits);
      body = '0;
      if (m != 0) begin
         for (int k = 1; k < CH_W; k++) begin
            if (k - 1 < m - 1) body[k-1] = chan[k];
         end
         for (int p = 0; p < DATA_W; p++) begin
            if (p == m + 1)      body[p] = 1'b1;
            else if (p == m)     body[p] = ~diff;
            else if (p == m - 1) body[p] = chan[0];
         end
      end
   end

   assign drive = (mux_bits != '0);
   assign word  = {body[DATA_W-2:0], 1'b0, {PAD{1'b0}}};
endmodule

// File: rtl/sarmux_tick.sv
module sarmux_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   generate
      if (HALF_DIV < 1) begin : g_bad
         $error("sarmux_tick: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!en)        cnt <= '0;
            else if (cnt == TOP) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == TOP);
      end
   endgenerate
endmodule

// File: rtl/sarmux_frame.sv
module sarmux_frame
   import sarmux_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int FRAME    = 16,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FRAME-1:0]  cmd_word,
   input  logic              cmd_drive,
   input  logic              tick,
   input  logic              miso,
   output logic              running,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   output logic              mosi_oe
);
   localparam int BW   = $clog2(FRAME);
   localparam int RXW  = FRAME - 2;
   localparam logic [BW-1:0] LAST = BW'(FRAME - 1);
   localparam int GAPMIN = 2 * HALF_DIV;
   localparam int HW   = $clog2(GAPMIN + 1);

   generate
      if (FRAME != 2 * DATA_W) begin : g_bad_frame
         $error("sarmux_frame: frame must be two data bytes");
      end
   endgenerate

   sarmux_state_e     state;
   logic              sclk_q, cs_n_q, busy_q, done_q, oe_q, m0_q, gap_q;
   logic [FRAME-1:0]  shreg;
   logic [RXW-1:0]    rx;
   logic [BW-1:0]     bitcnt;
   logic [DATA_W-1:0] result_q, pick;

   assign pick = m0_q ? rx[RXW-1 -: DATA_W] : rx[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b1;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         oe_q     <= 1'b0;
         m0_q     <= 1'b0;
         gap_q    <= 1'b0;
         shreg    <= '0;
         rx       <= '0;
         bitcnt   <= '0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_RUN;
                  cs_n_q <= 1'b0;
                  sclk_q <= 1'b0;
                  shreg  <= cmd_word;
                  oe_q   <= cmd_drive;
                  m0_q   <= ~cmd_drive;
                  rx     <= '0;
                  bitcnt <= '0;
                  busy_q <= 1'b1;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     rx     <= {rx[RXW-2:0], miso};
                  end else begin
                     sclk_q <= 1'b0;
                     if (bitcnt == LAST) begin
                        cs_n_q <= 1'b1;
                        oe_q   <= 1'b0;
                        shreg  <= '0;
                        gap_q  <= 1'b0;
                        state  <= ST_GAP;
                     end else begin
                        shreg  <= {shreg[FRAME-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_q) begin
                     state    <= ST_IDLE;
                     busy_q   <= 1'b0;
                     done_q   <= 1'b1;
                     result_q <= pick;
                  end else begin
                     gap_q <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign running = (state != ST_IDLE);
   assign busy    = busy_q;
   assign done    = done_q;
   assign result  = result_q;
   assign cs_n    = cs_n_q;
   assign sclk    = sclk_q;
   assign mosi    = shreg[FRAME-1];
   assign mosi_oe = oe_q;

   // gap checker: cycles cs_n has been high, saturating
   logic [HW-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hi_cnt <= HW'(GAPMIN);
      else if (!cs_n_q)                    hi_cnt <= '0;
      else if (hi_cnt != HW'(GAPMIN))      hi_cnt <= hi_cnt + 1'b1;
   end

   a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_q) |-> (hi_cnt >= HW'(GAPMIN)));

   a_r10_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sclk_q);

   a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q && $past(sclk_q)) |-> $stable(shreg[FRAME-1]));

   a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   a_r2_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_q) |-> (bitcnt == LAST));

   a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && !(state == ST_GAP && tick && gap_q)) |=> busy_q);
endmodule

// File: rtl/sar_mux_ctl.sv
module sar_mux_ctl #(
   parameter int DATA_W   = 8,
   parameter int CH_W     = 3,
   parameter int MAX_MUX  = 3,
   parameter int HALF_DIV = 2,
   localparam int FRAME   = 2 * DATA_W,
   localparam int MUX_W   = $clog2(MAX_MUX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MUX_W-1:0]  cfg_mux_bits,
   input  logic              req_start,
   input  logic [CH_W-1:0]   req_chan,
   input  logic              req_diff,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   output logic              mosi_oe,
   input  logic              miso
);
   logic [FRAME-1:0] cmd_word;
   logic             cmd_drive;
   logic             running;
   logic             tick;

   sarmux_cmd #(
      .DATA_W  (DATA_W),
      .FRAME   (FRAME),
      .CH_W    (CH_W),
      .MAX_MUX (MAX_MUX)
   ) u_cmd (
      .mux_bits (cfg_mux_bits),
      .chan     (req_chan),
      .diff     (req_diff),
      .word     (cmd_word),
      .drive    (cmd_drive)
   );

   sarmux_tick #(
      .HALF_DIV (HALF_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (running),
      .tick  (tick)
   );

   sarmux_frame #(
      .DATA_W   (DATA_W),
      .FRAME    (FRAME),
      .HALF_DIV (HALF_DIV)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_start),
      .cmd_word  (cmd_word),
      .cmd_drive (cmd_drive),
      .tick      (tick),
      .miso      (miso),
      .running   (running),
      .busy      (busy),
      .done      (done),
      .result    (result),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .mosi      (mosi),
      .mosi_oe   (mosi_oe)
   );

   a_r5_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mux_bits == '0 && !cs_n && $stable(cs_n)) |-> !mosi_oe);
endmodule

// File: tb/sar_mux_ctl_bench.sv
module sar_mux_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_DIV   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mux_bits = 2'd1;
   logic       req_start = 1'b0;
   logic [2:0] req_chan = 3'd0;
   logic       req_diff = 1'b0;
   logic       busy, done, cs_n, sclk, mosi, mosi_oe;
   logic [7:0] result;
   logic       miso = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_mux_ctl #(.HALF_DIV(HALF_DIV)) u_sar_mux_ctl (
      .clk (clk), .rst_n (rst_n), .cfg_mux_bits (cfg_mux_bits),
      .req_start (req_start), .req_chan (req_chan), .req_diff (req_diff),
      .busy (busy), .done (done), .result (result), .cs_n (cs_n),
      .sclk (sclk), .mosi (mosi), .mosi_oe (mosi_oe), .miso (miso)
   );

   // converter model and monitors, all on falling system-clock edges
   logic [15:0] resp = 16'h0;
   logic [15:0] cap;
   int          rises, frames, idx, oe_seen, mosi_hi_seen;
   int          mosi_bad, idle_bad, cs_bounce, hi_run, last_gap;
   logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

   always @(negedge clk) begin
      if (p_cs && !cs_n) begin
         frames++;
         last_gap = hi_run;
         idx = 15;
         miso = resp[15];
      end else if (!cs_n && p_sclk && !sclk && idx > 0) begin
         idx--;
         miso = resp[idx];
      end
      if (!p_cs && cs_n && rises != 16) cs_bounce++;
      if (!p_sclk && sclk) begin
         rises++;
         cap = {cap[14:0], mosi};
      end
      if (p_sclk && sclk && mosi != p_mosi) mosi_bad++;
      if (cs_n && sclk) idle_bad++;
      if (!cs_n && mosi_oe) oe_seen++;
      if (!cs_n && mosi) mosi_hi_seen++;
      hi_run = cs_n ? hi_run + 1 : 0;
      p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] want_cmd(input int m, input int ch, input bit d);
      logic [7:0] b;
      int c;
      b = 8'h0;
      c = ch % (1 << m);
      b = b | 8'(1 << (m + 1));
      if (!d) b = b | 8'(1 << m);
      b = b | 8'((c & 1) << (m - 1));
      if (m > 1) b = b | 8'(c >> 1);
      return {b << 1, 8'h00};
   endfunction

   task automatic clear_mon();
      rises = 0; frames = 0; cap = 16'h0; oe_seen = 0; mosi_hi_seen = 0;
      cs_bounce = 0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   task automatic convert(input int m, input int ch, input bit d, input logic [15:0] r);
      @(negedge clk);
      cfg_mux_bits = 2'(m); req_chan = 3'(ch); req_diff = d; resp = r;
      clear_mon();
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      wait_done();
   endtask

   task automatic t_reset();
      check(cs_n == 1'b1 && sclk == 1'b0, "R1 cs_n/sclk", {cs_n, sclk}, 2'b10);
      check(!busy && !done, "R1 busy/done", {busy, done}, 0);
      check(result == 8'h00, "R1 result", result, 0);
   endtask

   task automatic t_addr(input int m, input int ch, input bit d, input logic [7:0] val);
      convert(m, ch, d, {8'h5A ^ 8'(ch), val});
      check(cap == want_cmd(m, ch, d), "R3 command bits", cap, want_cmd(m, ch, d));
      check(result == val, "R4 second byte", result, val);
      check(rises == 16 && frames == 1 && cs_bounce == 0, "R2 sixteen clocks",
            rises, 16);
   endtask

   task automatic t_nomux(input logic [7:0] val);
      convert(0, 5, 1'b0, {2'b10, val, 6'b101101});
      check(result == val, "R5 skip two bits", result, val);
      check(oe_seen == 0 && mosi_hi_seen == 0, "R5 no drive", oe_seen, 0);
      check(rises == 16, "R2 sixteen clocks m0", rises, 16);
   endtask

   task automatic t_mask();
      convert(1, 7, 1'b0, 16'h00C3);
      check(cap == want_cmd(1, 1, 1'b0), "R11 chan mask m1", cap, want_cmd(1, 1, 1'b0));
      convert(2, 6, 1'b1, 16'h003C);
      check(cap == want_cmd(2, 2, 1'b1), "R11 chan mask m2", cap, want_cmd(2, 2, 1'b1));
   endtask

   task automatic t_busy();
      @(negedge clk);
      cfg_mux_bits = 2'd3; req_chan = 3'd2; req_diff = 1'b0; resp = 16'h00A5;
      clear_mon();
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      check(busy == 1'b1, "R7 busy after start", busy, 1);
      repeat (6) @(negedge clk);
      req_chan = 3'd7; req_diff = 1'b1; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      wait_done();
      check(!busy, "R7 busy low with done", busy, 0);
      @(negedge clk);
      check(!done, "R7 done one cycle", done, 0);
      repeat (4 * HALF_DIV + 4) @(negedge clk);
      check(frames == 1, "R8 no extra frame", frames, 1);
      check(cap == want_cmd(3, 2, 1'b0), "R8 first command kept", cap, want_cmd(3, 2, 1'b0));
      check(result == 8'hA5, "R8 first result kept", result, 8'hA5);
   endtask

   task automatic t_gap();
      @(negedge clk);
      cfg_mux_bits = 2'd2; req_chan = 3'd1; req_diff = 1'b0; resp = 16'h0011;
      clear_mon();
      req_start = 1'b1;
      wait_done();
      @(negedge clk);
      wait_done();
      req_start = 1'b0;
      check(frames == 2, "R9 back-to-back frames", frames, 2);
      check(last_gap >= 2 * HALF_DIV, "R9 cs high gap", last_gap, 2 * HALF_DIV);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      hi_run = 0; last_gap = 0; mosi_bad = 0; idle_bad = 0; idx = 0;
      clear_mon();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_addr(1, 1, 1'b0, 8'h81);
      t_addr(1, 0, 1'b1, 8'h7E);
      t_addr(2, 3, 1'b0, 8'hFF);
      t_addr(2, 2, 1'b1, 8'h00);
      t_addr(3, 5, 1'b0, 8'h3C);
      t_addr(3, 6, 1'b1, 8'hC5);
      t_nomux(8'hB7);
      t_nomux(8'h01);
      t_mask();
      t_busy();
      t_gap();
      check(mosi_bad == 0, "R6 mosi stable high sclk", mosi_bad, 0);
      check(idle_bad == 0, "R10 sclk low when idle", idle_bad, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule